// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This unit finds the element mask for a vector operation without the instruction naming a predicate register. Software fills a 16-entry key-value table through a write port. Each entry says that a given integer or floating-point destination register is predicated. The entry also names the integer register that holds the mask, and says whether that mask is inverted and whether inactive elements are zeroed.

The unit does not search the table on every lookup. After any table write it turns the table around into two 32-slot arrays indexed by register number, one for integer destinations and one for floating-point destinations. A lookup then takes the destination index and the int/fp flag, picks one slot, and drives the redirected predicate register index onto an integer register-file read port. It combines the returned data with the slot flags and presents an XLEN-bit mask and a zeroing flag. Bit i of the mask set to 1 means element i executes. When an element is inactive and the zeroing flag is set, the execution side writes zero into that element.

Top module: `pred_mask_lookup`

## Requirements
- R1: A table entry is 14 bits. Bits 4..0 hold the predicate register index. Bits 9..5 hold the key (destination) register index. Bit 10 selects the floating-point array when 1 and the integer array when 0. Bit 11 requests inversion, bit 12 requests zeroing and bit 13 is the bank bit. The entry selected by `cfg_idx_i` is overwritten when `cfg_we_i` is high.
- R2: After reset every slot of both arrays is disabled. Until the first write, every lookup returns an all-ones mask with `zero_o` low.
- R3: A lookup whose slot is disabled returns an all-ones mask with `zero_o` low.
- R4: A lookup whose slot is enabled drives that slot's predicate index on `rf_raddr_o` and returns `rf_rdata_i` as the mask. This holds for both integer and floating-point destinations, because the predicate is always read from the integer register file.
- R5: When the slot's invert flag is set, every bit of the returned register data is inverted before it reaches `mask_o`.
- R6: For an enabled slot with bank 0, `zero_o` equals the entry's zeroing bit.
- R7: An entry with bank bit 1 is accepted, but its slot is invalid. A lookup of that slot returns an all-ones mask with `zero_o` low.
- R8: Every write triggers a full rebuild from all 16 entries. Among entries with the same key and the same int/fp selector, the higher entry index wins. Entries still holding their reset value of zero map integer register 0 to predicate register 0 with no inversion and no zeroing.
- R9: A write sampled at clock edge k is not yet visible to lookups between edges k and k+1. It is visible from edge k+1 on. The lookup path from `dst_reg_i`, `dst_is_fp_i` and `rf_rdata_i` to the outputs is combinational.
- R10: The integer and floating-point arrays are independent. An entry for one kind of register leaves lookups of the same index in the other kind unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Table entry write enable |
| cfg_idx_i | input | 4 | Entry index to write |
| cfg_wdata_i | input | 14 | Entry contents (layout in R1) |
| dst_reg_i | input | 5 | Destination register index of the operation |
| dst_is_fp_i | input | 1 | 1 for a floating-point destination, 0 for an integer destination |
| rf_raddr_o | output | 5 | Integer register-file read address (redirected predicate register) |
| rf_rdata_i | input | XLEN | Integer register-file read data |
| mask_o | output | XLEN | Element mask, bit i set means element i executes |
| zero_o | output | 1 | Zero inactive elements |

## Verification
There are two latencies. A table write lands in the entry registers at its own edge and reaches the lookup arrays one edge later. A lookup is combinational against the arrays and the read data. The bench drives every input on a falling edge and samples one time unit later. After a write it checks once before the following rising edge, where the old mapping must still hold, and once after that edge, where the new mapping applies. The register file is a combinational function of the read address inside the bench, so each expected mask comes from the predicate index and invert flag that the requirements give for that lookup.

// File: rtl/pmlu_pkg.sv
package pmlu_pkg;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned NREG   = 1 << RIDX_W;

  // field order is the write-port layout
  typedef struct packed {
    logic              bank;
    logic              zero;
    logic              inv;
    logic              is_fp;
    logic [RIDX_W-1:0] key;
    logic [RIDX_W-1:0] pidx;
  } pent_t;

  typedef struct packed {
    logic              en;
    logic              bank;
    logic              zero;
    logic              inv;
    logic [RIDX_W-1:0] pidx;
  } slot_t;
endpackage

// File: rtl/pmlu_table.sv
module pmlu_table
  import pmlu_pkg::*;
#(
  parameter int unsigned NENT  = 16,
  localparam int unsigned IDX_W = $clog2(NENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  pent_t                  wdata_i,
  output pent_t [NENT-1:0]       tbl_o
);
  pent_t [NENT-1:0] tbl_q;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        tbl_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g)) tbl_q[g] <= wdata_i;
    end
  end

  assign tbl_o = tbl_q;

  // R1
  entry_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/pmlu_rebuild.sv
module pmlu_rebuild
  import pmlu_pkg::*;
#(
  parameter int unsigned NENT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  pent_t [NENT-1:0]    tbl_i,
  output slot_t [NREG-1:0]    int_slots_o,
  output slot_t [NREG-1:0]    fp_slots_o
);
  slot_t [NREG-1:0] int_d, fp_d, int_q, fp_q;
  logic             dirty_q;

  // ascending walk: later entries override earlier ones with the same key
  always_comb begin
    int_d = '0;
    fp_d  = '0;
    for (int i = 0; i < NENT; i++) begin
      slot_t s;
      s.en   = 1'b1;
      s.bank = tbl_i[i].bank;
      s.zero = tbl_i[i].zero;
      s.inv  = tbl_i[i].inv;
      s.pidx = tbl_i[i].pidx;
      if (tbl_i[i].is_fp) fp_d[tbl_i[i].key]  = s;
      else                int_d[tbl_i[i].key] = s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= 1'b0;
      int_q   <= '0;
      fp_q    <= '0;
    end else begin
      dirty_q <= we_i;
      if (dirty_q) begin
        int_q <= int_d;
        fp_q  <= fp_d;
      end
    end
  end

  assign int_slots_o = int_q;
  assign fp_slots_o  = fp_q;

  // R9
  rebuild_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> dirty_q);

  // R8
  arrays_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dirty_q |=> ($stable(int_q) && $stable(fp_q)));
endmodule

// File: rtl/pmlu_mask.sv
module pmlu_mask
  import pmlu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  slot_t             slot_i,
  output logic [RIDX_W-1:0] rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  output logic [XLEN-1:0]   mask_o,
  output logic              zero_o
);
  logic valid;

  // bank=1 is reserved: treat as unpredicated
  assign valid      = slot_i.en && !slot_i.bank;
  assign rf_raddr_o = slot_i.pidx;

  always_comb begin
    if (!valid)          mask_o = '1;
    else if (slot_i.inv) mask_o = ~rf_rdata_i;
    else                 mask_o = rf_rdata_i;
  end

  assign zero_o = valid && slot_i.zero;
endmodule

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup
  import pmlu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NENT = 16,
  localparam int unsigned IDX_W = $clog2(NENT),
  localparam int unsigned ENT_W = $bits(pent_t)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [ENT_W-1:0]     cfg_wdata_i,
  input  logic [RIDX_W-1:0]    dst_reg_i,
  input  logic                 dst_is_fp_i,
  output logic [RIDX_W-1:0]    rf_raddr_o,
  input  logic [XLEN-1:0]      rf_rdata_i,
  output logic [XLEN-1:0]      mask_o,
  output logic                 zero_o
);
  pent_t [NENT-1:0] tbl;
  slot_t [NREG-1:0] int_slots, fp_slots;
  slot_t            sel;

  pmlu_table #(.NENT(NENT)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (pent_t'(cfg_wdata_i)),
    .tbl_o   (tbl)
  );

  pmlu_rebuild #(.NENT(NENT)) u_rebuild (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .tbl_i       (tbl),
    .int_slots_o (int_slots),
    .fp_slots_o  (fp_slots)
  );

  assign sel = dst_is_fp_i ? fp_slots[dst_reg_i] : int_slots[dst_reg_i];

  pmlu_mask #(.XLEN(XLEN)) u_mask (
    .slot_i     (sel),
    .rf_raddr_o (rf_raddr_o),
    .rf_rdata_i (rf_rdata_i),
    .mask_o     (mask_o),
    .zero_o     (zero_o)
  );

  logic wr_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_seen_q <= 1'b0;
    else if (cfg_we_i) wr_seen_q <= 1'b1;
  end

  // R2
  reset_unpredicated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_seen_q |-> (mask_o == '1 && !zero_o));

  // R6
  zero_needs_pred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (mask_o == rf_rdata_i || mask_o == ~rf_rdata_i));
endmodule

// File: tb/pred_mask_lookup_bench.sv
module pred_mask_lookup_bench;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [3:0]      widx = '0;
  logic [13:0]     wdata = '0;
  logic [4:0]      dreg = '0;
  logic            dfp = 1'b0;
  logic [4:0]      raddr;
  logic [XLEN-1:0] rdata, mask;
  logic            zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [XLEN-1:0] rf_val(input logic [4:0] a);
    return {8{3'b101, a}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  assign rdata = rf_val(raddr);

  pred_mask_lookup #(.XLEN(XLEN)) u_pred_mask_lookup (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(widx),
    .cfg_wdata_i(wdata), .dst_reg_i(dreg), .dst_is_fp_i(dfp),
    .rf_raddr_o(raddr), .rf_rdata_i(rdata), .mask_o(mask), .zero_o(zero)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entry: {bank, zero, inv, is_fp, key[4:0], pidx[4:0]}
  function automatic logic [13:0] ent(input bit b, input bit z, input bit i, input bit f,
                                      input logic [4:0] k, input logic [4:0] p);
    return {b, z, i, f, k, p};
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [13:0] d);
    @(negedge clk); we = 1'b1; widx = idx; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic look(input bit f, input logic [4:0] r);
    dfp = f; dreg = r; #1;
  endtask

  task automatic expect_pred(input string req, input bit en, input logic [4:0] p,
                             input bit inv, input bit z);
    logic [XLEN-1:0] em;
    em = !en ? '1 : (inv ? ~rf_val(p) : rf_val(p));
    chk(req, mask, em);
    chk(req, {63'd0, zero}, {63'd0, en & z});
    if (en) chk(req, {59'd0, raddr}, {59'd0, p});
  endtask

  // {fp, reg, en, pidx, inv, zero}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 5'd3,  1'b1, 5'd7,  1'b0, 1'b0},  // R4 R1
    {1'b1, 5'd3,  1'b1, 5'd9,  1'b1, 1'b1},  // R4 R5 R6 R10
    {1'b0, 5'd10, 1'b1, 5'd20, 1'b1, 1'b0},  // R8 later entry wins
    {1'b1, 5'd31, 1'b0, 5'd0,  1'b0, 1'b0},  // R7 bank=1
    {1'b0, 5'd0,  1'b1, 5'd0,  1'b0, 1'b0},  // R8 zero entries
    {1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0},  // R3 R10
    {1'b0, 5'd5,  1'b0, 5'd0,  1'b0, 1'b0},  // R3
    {1'b1, 5'd10, 1'b0, 5'd0,  1'b0, 1'b0}   // R3 R10
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look(1'b0, 5'd0); expect_pred("R2", 1'b0, 5'd0, 1'b0, 1'b0);
    look(1'b1, 5'd5); expect_pred("R2", 1'b0, 5'd0, 1'b0, 1'b0);

    wr(4'd0, ent(0, 0, 0, 0, 5'd3, 5'd7));
    look(1'b0, 5'd3); expect_pred("R9", 1'b0, 5'd0, 1'b0, 1'b0);
    @(negedge clk);
    look(1'b0, 5'd3); expect_pred("R9", 1'b1, 5'd7, 1'b0, 1'b0);

    wr(4'd1, ent(0, 1, 1, 1, 5'd3, 5'd9));
    wr(4'd2, ent(0, 1, 0, 0, 5'd10, 5'd12));
    wr(4'd3, ent(0, 0, 1, 0, 5'd10, 5'd20));
    wr(4'd4, ent(1, 1, 0, 1, 5'd31, 5'd31));
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      look(VEC[i][13], VEC[i][12:8]);
      expect_pred($sformatf("R3/R4/R5/R6/R7/R8/R10 vec%0d", i),
                  VEC[i][7], VEC[i][6:2], VEC[i][1], VEC[i][0]);
    end

    // R8: moving entry 3 to key 11 restores entry 2 for int reg 10
    wr(4'd3, ent(0, 0, 1, 0, 5'd11, 5'd20));
    @(negedge clk);
    look(1'b0, 5'd10); expect_pred("R8", 1'b1, 5'd12, 1'b0, 1'b1);
    look(1'b0, 5'd11); expect_pred("R8", 1'b1, 5'd20, 1'b1, 1'b0);

    // R7: bank cleared on same key becomes valid
    wr(4'd4, ent(0, 1, 0, 1, 5'd31, 5'd31));
    @(negedge clk);
    look(1'b1, 5'd31); expect_pred("R7", 1'b1, 5'd31, 1'b0, 1'b1);

    // R2: reset clears all slots again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(1'b0, 5'd3); expect_pred("R2", 1'b0, 5'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule